// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a host reach a bank of 256 registers that runs on its own clock. Each register is 32 bits wide and is selected by an 8-bit index. The host never addresses that bank directly. It sees two 32-bit words: a command word and a data word.

To start an access, the host writes the command word with its go/busy bit set. The block then raises a level request. The request is carried into the remote clock through a two-flop synchronizer. The remote side performs the access and answers with a level acknowledge, which returns through a second two-flop synchronizer. Busy clears after both sides have dropped their handshake lines. For a write, the data word is copied into the selected remote register. For a read, the remote value lands in the data word before busy clears.

The host control is a three-state machine: `H_IDLE`, `H_REQ` and `H_RELEASE`. From `H_IDLE` the host goes to `H_REQ` on a go write. It moves from `H_REQ` to `H_RELEASE` on the synchronized acknowledge, and from `H_RELEASE` back to `H_IDLE` once the acknowledge has dropped. The remote side has two states, `R_IDLE` and `R_SERVE`. It goes from `R_IDLE` to `R_SERVE` on the synchronized request, performing the access in that same cycle. It returns from `R_SERVE` to `R_IDLE` once the request has dropped.

Top module: `csr_bridge`

## Requirements
- R1: After reset, the command word and the data word both read 0x00000000.
- R2: In the command word, bit 31 is busy, bit 30 is the direction (1 = read, 0 = write) and bits 7:0 are the remote index. Bits 29:8 always read zero and ignore writes.
- R3: A host write to the command word with bit 31 = 1 while idle starts an access. Busy reads 1 from the next host clock onward.
- R4: A command write with bit 31 = 0 only updates the direction and index fields. Busy stays 0 and no remote register changes.
- R5: A write access stores the current data word into the remote register at the index.
- R6: A read access places the remote register value into the data word. That value is already present when busy is first seen as 0.
- R7: Busy clears by itself when the access has completed. A host write of bit 31 = 0 during busy does not clear it.
- R8: While busy is 1, host writes to the command word and to the data word are ignored.
- R9: The request is held high until the acknowledge is seen. The index, direction and write data stay stable while the request is high.
- R10: The command word is at host offset 0xA4 and the data word at offset 0xA8. All other offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| host_clk | input | 1 | Host clock |
| host_rst_n | input | 1 | Host active-low reset |
| host_wr_en | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 8 | Host byte offset for reads and writes |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Combinational read data for host_addr |
| remote_clk | input | 1 | Remote register bank clock |
| remote_rst_n | input | 1 | Remote active-low reset |

## Verification
A host machine stuck outside `H_IDLE` shows at once as busy never clearing, which the bench's poll timeout catches within a few hundred host cycles. A machine that leaves `H_REQ` too early shows as stale read data on the first cycle busy reads 0. A remote side that misses or repeats an access shows on the next read-back of that index, because the bench keeps its own model of all 256 registers. Broken blocking of host writes during busy shows in the command or data word read back right after the access ends.

// File: rtl/csr_bridge_pkg.sv
package csr_bridge_pkg;
    localparam int HOST_AW  = 8;
    localparam int REG_AW   = 8;
    localparam int DATA_W   = 32;
    localparam logic [HOST_AW-1:0] OFS_CMD  = 8'hA4;
    localparam logic [HOST_AW-1:0] OFS_DATA = 8'hA8;
    localparam int BIT_GO  = 31;
    localparam int BIT_DIR = 30;

    typedef enum logic [1:0] {
        H_IDLE    = 2'd0,
        H_REQ     = 2'd1,
        H_RELEASE = 2'd2
    } host_state_t;

    typedef enum logic {
        R_IDLE  = 1'b0,
        R_SERVE = 1'b1
    } remote_state_t;
endpackage

// File: rtl/csr_sync.sv
module csr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr <= '0;
                else        sr <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr <= '0;
                else        sr <= {sr[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sr[STAGES-1];
endmodule

// File: rtl/csr_host_side.sv
module csr_host_side
    import csr_bridge_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [HOST_AW-1:0] addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    input  logic               ack_s,
    input  logic [DATA_W-1:0]  remote_rd,
    output logic               req,
    output logic               busy,
    output logic [REG_AW-1:0]  cmd_addr,
    output logic               cmd_dir,
    output logic [DATA_W-1:0]  data_q
);
    host_state_t state, state_nx;

    logic cmd_wr, data_wr;
    assign cmd_wr  = wr_en && (addr == OFS_CMD);
    assign data_wr = wr_en && (addr == OFS_DATA);

    always_comb begin
        state_nx = state;
        unique case (state)
            H_IDLE:    if (cmd_wr && wdata[BIT_GO]) state_nx = H_REQ;
            H_REQ:     if (ack_s)                   state_nx = H_RELEASE;
            H_RELEASE: if (!ack_s)                  state_nx = H_IDLE;
            default:                                state_nx = H_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= H_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        req  = 1'b0;
        busy = 1'b1;
        unique case (state)
            H_IDLE:    busy = 1'b0;
            H_REQ:     req  = 1'b1;
            H_RELEASE: req  = 1'b0;
            default:   busy = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_addr <= '0;
            cmd_dir  <= 1'b0;
            data_q   <= '0;
        end else begin
            if (state == H_IDLE && cmd_wr) begin
                cmd_addr <= wdata[REG_AW-1:0];
                cmd_dir  <= wdata[BIT_DIR];
            end
            if (state == H_IDLE && data_wr)
                data_q <= wdata;
            else if (state == H_REQ && ack_s && cmd_dir)
                data_q <= remote_rd;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == OFS_CMD) begin
            rdata[BIT_GO]       = busy;
            rdata[BIT_DIR]      = cmd_dir;
            rdata[REG_AW-1:0]   = cmd_addr;
        end else if (addr == OFS_DATA) begin
            rdata = data_q;
        end
    end
endmodule

// File: rtl/csr_remote_bank.sv
module csr_remote_bank
    import csr_bridge_pkg::*;
#(
    parameter int DEPTH = 1 << REG_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_s,
    input  logic [REG_AW-1:0] idx,
    input  logic              dir_rd,
    input  logic [DATA_W-1:0] wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rd_q
);
    remote_state_t state, state_nx;
    logic [DATA_W-1:0] mem [DEPTH];

    always_comb begin
        state_nx = state;
        unique case (state)
            R_IDLE:  if (req_s)  state_nx = R_SERVE;
            R_SERVE: if (!req_s) state_nx = R_IDLE;
            default:             state_nx = R_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= R_IDLE;
        else        state <= state_nx;
    end

    assign ack = (state == R_SERVE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (state == R_IDLE && req_s) begin
            if (dir_rd) rd_q      <= mem[idx];
            else        mem[idx]  <= wdata;
        end
    end
endmodule

// File: rtl/csr_bridge.sv
module csr_bridge
    import csr_bridge_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               host_clk,
    input  logic               host_rst_n,
    input  logic               host_wr_en,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata,
    input  logic               remote_clk,
    input  logic               remote_rst_n
);
    logic              req_lvl, req_sync;
    logic              ack_lvl, ack_sync;
    logic              busy;
    logic [REG_AW-1:0] cmd_addr;
    logic              cmd_dir;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] remote_rd;

    csr_host_side u_host (
        .clk       (host_clk),
        .rst_n     (host_rst_n),
        .wr_en     (host_wr_en),
        .addr      (host_addr),
        .wdata     (host_wdata),
        .rdata     (host_rdata),
        .ack_s     (ack_sync),
        .remote_rd (remote_rd),
        .req       (req_lvl),
        .busy      (busy),
        .cmd_addr  (cmd_addr),
        .cmd_dir   (cmd_dir),
        .data_q    (data_q)
    );

    csr_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (remote_clk),
        .rst_n (remote_rst_n),
        .d     (req_lvl),
        .q     (req_sync)
    );

    csr_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (host_clk),
        .rst_n (host_rst_n),
        .d     (ack_lvl),
        .q     (ack_sync)
    );

    csr_remote_bank u_bank (
        .clk    (remote_clk),
        .rst_n  (remote_rst_n),
        .req_s  (req_sync),
        .idx    (cmd_addr),
        .dir_rd (cmd_dir),
        .wdata  (data_q),
        .ack    (ack_lvl),
        .rd_q   (remote_rd)
    );
endmodule

// File: rtl/csr_bridge_chk.sv
module csr_bridge_chk
    import csr_bridge_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [HOST_AW-1:0] addr,
    input logic [DATA_W-1:0]  wdata,
    input logic [DATA_W-1:0]  rdata,
    input logic               busy,
    input logic               req,
    input logic               ack_s,
    input logic [REG_AW-1:0]  cmd_addr,
    input logic               cmd_dir,
    input logic [DATA_W-1:0]  data_q
);
    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == OFS_CMD) |-> (rdata[29:8] == '0));

    assert_go_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_en && addr == OFS_CMD && wdata[BIT_GO]) |=> busy);

    assert_idle_no_go_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_en && addr == OFS_CMD && !wdata[BIT_GO]) |=> !busy);

    assert_req_means_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> busy);

    assert_cmd_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && addr == OFS_CMD) |=> ($stable(cmd_addr) && $stable(cmd_dir)));

    assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack_s) |=> req);

    assert_fields_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> (!req || ($stable(cmd_addr) && $stable(cmd_dir))));

    assert_wdata_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !cmd_dir) |=> (!req || $stable(data_q)));

    assert_other_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != OFS_CMD && addr != OFS_DATA) |-> (rdata == '0));
endmodule

bind csr_bridge csr_bridge_chk u_chk (
    .clk      (host_clk),
    .rst_n    (host_rst_n),
    .wr_en    (host_wr_en),
    .addr     (host_addr),
    .wdata    (host_wdata),
    .rdata    (host_rdata),
    .busy     (busy),
    .req      (req_lvl),
    .ack_s    (ack_sync),
    .cmd_addr (cmd_addr),
    .cmd_dir  (cmd_dir),
    .data_q   (data_q)
);

// File: tb/csr_bridge_tb.sv
`timescale 1ns/1ps
module csr_bridge_tb;
    logic        host_clk = 1'b0;
    logic        remote_clk = 1'b0;
    logic        host_rst_n = 1'b0;
    logic        remote_rst_n = 1'b0;
    logic        host_wr_en = 1'b0;
    logic [7:0]  host_addr = 8'h00;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] model [256];

    always #2.5  host_clk   = ~host_clk;
    always #3.65 remote_clk = ~remote_clk;

    csr_bridge u_dut (
        .host_clk     (host_clk),
        .host_rst_n   (host_rst_n),
        .host_wr_en   (host_wr_en),
        .host_addr    (host_addr),
        .host_wdata   (host_wdata),
        .host_rdata   (host_rdata),
        .remote_clk   (remote_clk),
        .remote_rst_n (remote_rst_n)
    );

    function automatic logic [31:0] cmd_word(input logic b, input logic d, input logic [7:0] a);
        return {b, d, 22'd0, a};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge host_clk);
        host_addr  = a;
        host_wdata = d;
        host_wr_en = 1'b1;
        @(negedge host_clk);
        host_wr_en = 1'b0;
    endtask

    task automatic host_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge host_clk);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] v;
        int n;
        n = 0;
        host_read(8'hA4, v);
        while (v[31] && n < 400) begin
            host_read(8'hA4, v);
            n++;
        end
        checks++;
        if (v[31]) begin
            errors++;
            $display("FAIL %s: busy stuck got %08h expected %08h", req, v, v & 32'h7FFF_FFFF);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        host_write(8'hA8, d);
        host_write(8'hA4, cmd_word(1'b1, 1'b0, a));
        wait_idle("R7");
        model[a] = d;
    endtask

    task automatic do_read_check(input logic [7:0] a, input string req);
        logic [31:0] v;
        host_write(8'hA4, cmd_word(1'b1, 1'b1, a));
        wait_idle("R7");
        host_read(8'hA8, v);
        check(req, v, model[a]);
    endtask

    initial begin
        int unused_seed;
        logic [31:0] v;
        for (int i = 0; i < 256; i++) model[i] = '0;
        unused_seed = $urandom(32'h0C5A_17E3);

        repeat (4) @(negedge host_clk);
        host_rst_n = 1'b1;
        remote_rst_n = 1'b1;
        repeat (2) @(negedge host_clk);

        host_read(8'hA4, v); check("R1 cmd reset", v, 32'h0);
        host_read(8'hA8, v); check("R1 data reset", v, 32'h0);
        host_read(8'h00, v); check("R10 unmapped", v, 32'h0);
        host_read(8'hA0, v); check("R10 unmapped", v, 32'h0);

        host_write(8'hA4, 32'h7FFF_FF55);
        host_read(8'hA4, v); check("R2 R4 fields only", v, cmd_word(1'b0, 1'b1, 8'h55));
        host_read(8'hA8, v); check("R4 data untouched", v, 32'h0);

        host_write(8'hA8, 32'hDEAD_BEEF);
        host_read(8'hA8, v); check("R10 data offset", v, 32'hDEAD_BEEF);

        host_write(8'hA4, cmd_word(1'b1, 1'b0, 8'h10));
        host_read(8'hA4, v); check("R3 busy set", v, cmd_word(1'b1, 1'b0, 8'h10));
        host_write(8'hA8, 32'h1111_1111);
        host_write(8'hA4, cmd_word(1'b0, 1'b1, 8'h22));
        host_read(8'hA4, v); check("R7 R8 cmd locked", v, cmd_word(1'b1, 1'b0, 8'h10));
        wait_idle("R7");
        model[8'h10] = 32'hDEAD_BEEF;
        host_read(8'hA8, v); check("R8 data locked", v, 32'hDEAD_BEEF);
        host_read(8'hA4, v); check("R7 idle cmd", v, cmd_word(1'b0, 1'b0, 8'h10));

        host_write(8'hA8, 32'h0);
        do_read_check(8'h10, "R5 R6 readback");
        do_read_check(8'h55, "R4 no access on go=0");

        do_write(8'h00, 32'hA5A5_0001);
        do_write(8'hFF, 32'h5A5A_FFFE);
        do_read_check(8'h00, "R5 R6 index 00");
        do_read_check(8'hFF, "R5 R6 index FF");

        for (int k = 0; k < 40; k++) begin
            logic [7:0]  ra;
            logic [31:0] rd;
            ra = 8'($urandom_range(0, 255));
            rd = $urandom;
            if ($urandom_range(0, 1) == 0) begin
                do_write(ra, rd);
            end else begin
                host_write(8'hA8, rd);
                host_write(8'hA4, cmd_word(1'b1, 1'b1, ra));
                host_write(8'hA8, ~rd);
                wait_idle("R7");
                host_read(8'hA8, v);
                check("R6 R8 random read", v, model[ra]);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge host_clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got %08h expected %08h", 32'h0, 32'h1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule